// File: doc/BRIEF.md
# CAN receive frame destuffer and parser

This block takes the received CAN bit stream, one already sampled bit for each bit-time strobe, and rebuilds a data or remote frame. A dominant bit seen while the block is idle starts a frame. From that start bit through the CRC field, the block removes the stuff bits. It splits the destuffed bits into identifier, control and data fields. It switches between the 11-bit and the 29-bit identifier layouts according to the format bit that arrives in the thirteenth bit position after the start bit.

The block computes its own CRC-15 over the destuffed bits and compares it with the received CRC sequence. It also checks the fixed recessive delimiters and the end-of-frame field. A good frame ends in a one-cycle valid pulse, and the decoded fields are held on the outputs until the next good frame. A failed frame ends in a one-cycle pulse on one of three error outputs, and the block returns to idle. Bit timing, acknowledge driving, error counting and transmission are handled elsewhere.

Top module: `can_rx_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, frm_valid, err_stuff, err_crc and err_form are 0, and frm_id, frm_ext, frm_rtr, frm_dlc and frm_data are all zero.
- R2: Standard layout, sent after the start bit and most significant bit first: 11-bit identifier, RTR, format bit = 0, one reserved bit, 4-bit DLC. frm_id[10:0] holds the identifier, frm_id[28:11] is 0 and frm_ext is 0. Data byte k, also sent most significant bit first, appears on frm_data[8k+7:8k], with byte 0 being the first byte received.
- R3: Extended layout, after the start bit: 11 high identifier bits, a recessive substitute bit, format bit = 1, 18 low identifier bits, RTR, two reserved bits, 4-bit DLC. frm_id = {high 11, low 18} and frm_ext = 1.
- R4: From the start bit through the CRC field, a bit that follows five consecutive equal bits is a stuff bit of the opposite value and is dropped, not decoded. A stuff bit that falls right after the last CRC bit is also dropped.
- R5: When RTR is 1, the CRC follows the DLC directly. frm_rtr is 1, frm_data is 0, and frm_dlc reports the received DLC.
- R6: A data frame carries 8 × DLC data bits, with a DLC above 8 taken as 8 bytes. frm_dlc reports the raw DLC, and any byte beyond the received count reads 0.
- R7: The CRC-15 uses polynomial 0x4599, starts from zero, and covers the destuffed bits from the start bit to the end of the data field. A mismatch gives a pulse on err_crc, with no frm_valid, once the recessive CRC delimiter is received.
- R8: A sixth consecutive equal bit anywhere from the start bit through the bit after the CRC gives a pulse on err_stuff. The frame is abandoned, and the next dominant bit starts a new frame.
- R9: A dominant CRC delimiter, ACK delimiter or end-of-frame bit gives a pulse on err_form, with no frm_valid. The ACK slot may take either value.
- R10: frm_valid, err_stuff, err_crc and err_form are each a one-cycle pulse, at most one at a time. Each appears in the cycle after the clock edge that sampled the deciding strobed bit; for frm_valid that bit is the seventh end-of-frame bit. The frm_* fields change only together with frm_valid.
- R11: rx_bit is looked at only in cycles with bit_strobe high. A dominant level without a strobe, or any number of recessive bits while idle, does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One-cycle marker that rx_bit holds a new sampled bit |
| rx_bit | input | 1 | Sampled bus level, 0 = dominant |
| frm_valid | output | 1 | One-cycle pulse: a good frame has completed |
| frm_id | output | 29 | Identifier, with the standard identifier in the low 11 bits |
| frm_ext | output | 1 | 1 = extended layout |
| frm_rtr | output | 1 | Remote request flag |
| frm_dlc | output | 4 | Received data length code |
| frm_data | output | MAX_BYTES*8 | Data bytes, byte 0 in the low 8 bits |
| err_stuff | output | 1 | One-cycle pulse: stuff rule broken |
| err_crc | output | 1 | One-cycle pulse: CRC mismatch |
| err_form | output | 1 | One-cycle pulse: fixed-form bit was dominant |

## Verification
Every result of this block is a registered one-cycle pulse, due in the clock cycle right after the edge that sampled the strobed bit that decides it. For a good frame that bit is the seventh end-of-frame bit; for an error it is the offending bit. The driver pushes the outcome it expects for each frame into a queue before it sends the bits. The monitor samples on the falling clock edge, so it sees the pulse in the middle of the cycle it is due. At each pulse the monitor requires that a strobe was sampled at the edge just before, then pops the queue and compares the kind of outcome and every field. Any outcome still left in the queue at the end counts as a missing pulse.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_CRC, ST_CDEL, ST_ACK, ST_ADEL, ST_EOF
  } rx_state_t;

  function automatic logic [CRC_W-1:0] crc15_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc15_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/can_destuff.sv
module can_destuff #(
  parameter int RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic rx_bit,
  input  logic restart,
  input  logic active,
  output logic is_stuff,
  output logic stuff_err
);
  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic          last_q;
  logic [RW-1:0] run_q;
  logic          at_limit;

  assign at_limit  = (run_q == RW'(RUN_LIMIT));
  assign is_stuff  = strobe && active && at_limit && (rx_bit != last_q);
  assign stuff_err = strobe && active && at_limit && (rx_bit == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      run_q  <= '0;
    end else if (strobe) begin
      if (restart) begin
        last_q <= rx_bit;
        run_q  <= RW'(1);
      end else if (active) begin
        if (rx_bit == last_q && !at_limit) run_q <= run_q + RW'(1);
        else                               run_q <= RW'(1);
        last_q <= rx_bit;
      end
    end
  end
endmodule

// File: rtl/can_crc15.sv
module can_crc15 import can_rx_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             rx_bit,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clear) crc <= '0;
    else if (step)    crc <= crc15_step(crc, rx_bit);
  end
endmodule

// File: rtl/can_rx_parser.sv
module can_rx_parser import can_rx_pkg::*; #(
  parameter int MAX_BYTES = 8,
  parameter int RUN_LIMIT = 5,
  parameter int EOF_BITS  = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_strobe,
  input  logic                   rx_bit,
  output logic                   frm_valid,
  output logic [28:0]            frm_id,
  output logic                   frm_ext,
  output logic                   frm_rtr,
  output logic [3:0]             frm_dlc,
  output logic [MAX_BYTES*8-1:0] frm_data,
  output logic                   err_stuff,
  output logic                   err_crc,
  output logic                   err_form
);
  localparam int DBITS_MAX = MAX_BYTES * 8;
  localparam int HDR_STD   = 18;
  localparam int HDR_EXT   = 38;
  localparam int IDE_POS   = 12;
  localparam int CNT_W     = $clog2(DBITS_MAX > HDR_EXT ? DBITS_MAX : HDR_EXT);
  localparam int DB_W      = $clog2(DBITS_MAX + 1);
  localparam int DI_W      = $clog2(DBITS_MAX);

  rx_state_t              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [HDR_EXT-2:0]     hdr_q;
  logic                   ide_q;
  logic [28:0]            w_id;
  logic                   w_ext, w_rtr;
  logic [3:0]             w_dlc;
  logic [DB_W-1:0]        dbits_q;
  logic [DBITS_MAX-1:0]   data_q;
  logic [CRC_W-1:0]       crc_rx_q;
  logic [CRC_W-1:0]       crc_calc;

  logic stuff_active, sof, is_stuff, stuff_err, dv, crc_step;
  logic [HDR_EXT-1:0] hdr_nx;
  logic hdr_last, rtr_nx;
  logic [3:0] dlc_nx;
  logic [28:0] id_nx;
  logic [DB_W-1:0] dbits_nx;
  logic [DI_W-1:0] didx;
  logic [CRC_W-1:0] crc_rx_nx;
  logic unused_hdr_bits;

  assign stuff_active = (state_q == ST_HDR) || (state_q == ST_DATA) ||
                        (state_q == ST_CRC) || (state_q == ST_CDEL);
  assign sof      = bit_strobe && (state_q == ST_IDLE) && !rx_bit;
  assign dv       = bit_strobe && stuff_active && !is_stuff && !stuff_err;
  assign crc_step = dv && ((state_q == ST_HDR) || (state_q == ST_DATA));

  can_destuff #(.RUN_LIMIT(RUN_LIMIT)) u_destuff (
    .clk(clk), .rst(rst), .strobe(bit_strobe), .rx_bit(rx_bit),
    .restart(sof), .active(stuff_active),
    .is_stuff(is_stuff), .stuff_err(stuff_err)
  );

  can_crc15 u_crc (
    .clk(clk), .rst(rst), .clear(sof), .step(crc_step),
    .rx_bit(rx_bit), .crc(crc_calc)
  );

  assign hdr_nx   = {hdr_q, rx_bit};
  assign hdr_last = ((cnt_q == CNT_W'(HDR_STD - 1)) && !ide_q) ||
                    ((cnt_q == CNT_W'(HDR_EXT - 1)) && ide_q);
  assign dlc_nx   = hdr_nx[3:0];
  assign rtr_nx   = hdr_nx[6];
  assign id_nx    = ide_q ? {hdr_nx[37:27], hdr_nx[24:7]} : {18'd0, hdr_nx[17:7]};
  assign didx     = cnt_q[DI_W-1:0] ^ DI_W'(7);
  assign crc_rx_nx = {crc_rx_q[CRC_W-2:0], rx_bit};
  assign unused_hdr_bits = ^{hdr_nx[26:25], hdr_nx[5:4]};

  always_comb begin
    if (rtr_nx)                      dbits_nx = '0;
    else if (32'(dlc_nx) > MAX_BYTES) dbits_nx = DB_W'(DBITS_MAX);
    else                             dbits_nx = DB_W'(dlc_nx) << 3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      ide_q     <= 1'b0;
      w_id      <= '0;
      w_ext     <= 1'b0;
      w_rtr     <= 1'b0;
      w_dlc     <= '0;
      dbits_q   <= '0;
      data_q    <= '0;
      crc_rx_q  <= '0;
      frm_valid <= 1'b0;
      frm_id    <= '0;
      frm_ext   <= 1'b0;
      frm_rtr   <= 1'b0;
      frm_dlc   <= '0;
      frm_data  <= '0;
      err_stuff <= 1'b0;
      err_crc   <= 1'b0;
      err_form  <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      err_stuff <= 1'b0;
      err_crc   <= 1'b0;
      err_form  <= 1'b0;
      if (stuff_err) begin
        err_stuff <= 1'b1;
        state_q   <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (sof) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
            ide_q   <= 1'b0;
            data_q  <= '0;
          end
          ST_HDR: if (dv) begin
            hdr_q <= hdr_nx[HDR_EXT-2:0];
            if (cnt_q == CNT_W'(IDE_POS)) ide_q <= rx_bit;
            if (hdr_last) begin
              w_id    <= id_nx;
              w_ext   <= ide_q;
              w_rtr   <= rtr_nx;
              w_dlc   <= dlc_nx;
              dbits_q <= dbits_nx;
              cnt_q   <= '0;
              state_q <= (dbits_nx == '0) ? ST_CRC : ST_DATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_DATA: if (dv) begin
            data_q[didx] <= rx_bit;
            if (DB_W'(cnt_q) == dbits_q - DB_W'(1)) begin
              cnt_q   <= '0;
              state_q <= ST_CRC;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_CRC: if (dv) begin
            crc_rx_q <= crc_rx_nx;
            if (cnt_q == CNT_W'(CRC_W - 1)) state_q <= ST_CDEL;
            else                            cnt_q   <= cnt_q + CNT_W'(1);
          end
          ST_CDEL: if (dv) begin
            if (!rx_bit) begin
              err_form <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (crc_rx_q != crc_calc) begin
              err_crc <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_ACK;
            end
          end
          ST_ACK: if (bit_strobe) state_q <= ST_ADEL;
          ST_ADEL: if (bit_strobe) begin
            if (rx_bit) begin
              state_q <= ST_EOF;
              cnt_q   <= '0;
            end else begin
              err_form <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end
          ST_EOF: if (bit_strobe) begin
            if (!rx_bit) begin
              err_form <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (cnt_q == CNT_W'(EOF_BITS - 1)) begin
              frm_valid <= 1'b1;
              frm_id    <= w_id;
              frm_ext   <= w_ext;
              frm_rtr   <= w_rtr;
              frm_dlc   <= w_dlc;
              frm_data  <= data_q;
              state_q   <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_rx_parser_chk.sv
module can_rx_parser_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_strobe,
  input logic                   frm_valid,
  input logic [28:0]            frm_id,
  input logic                   frm_ext,
  input logic                   frm_rtr,
  input logic [3:0]             frm_dlc,
  input logic [MAX_BYTES*8-1:0] frm_data,
  input logic                   err_stuff,
  input logic                   err_crc,
  input logic                   err_form
);
  int nbytes;
  assign nbytes = frm_rtr ? 0 : ((int'(frm_dlc) > MAX_BYTES) ? MAX_BYTES : int'(frm_dlc));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frm_valid, err_stuff, err_crc, err_form}));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> !frm_valid);

  a_r10_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (frm_valid || err_stuff || err_crc || err_form) |-> $past(bit_strobe));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |-> ($stable(frm_id) && $stable(frm_data) && $stable(frm_dlc) &&
                    $stable(frm_ext) && $stable(frm_rtr)));

  a_r5_remote_no_data: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_rtr) |-> (frm_data == '0));

  a_r2_std_id_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_ext) |-> (frm_id[28:11] == '0));

  a_r6_unused_bytes_zero: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> ((frm_data >> (nbytes * 8)) == '0));
endmodule

bind can_rx_parser can_rx_parser_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .frm_valid(frm_valid),
  .frm_id(frm_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
  .frm_data(frm_data), .err_stuff(err_stuff), .err_crc(err_crc), .err_form(err_form)
);

// File: tb/can_rx_parser_bench.sv
`timescale 1ns/1ps
module can_rx_parser_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_strobe = 1'b0;
  logic rx_bit = 1'b1;
  logic frm_valid, frm_ext, frm_rtr, err_stuff, err_crc, err_form;
  logic [28:0] frm_id;
  logic [3:0]  frm_dlc;
  logic [63:0] frm_data;

  always #4 clk = ~clk;

  can_rx_parser u_can_rx_parser (
    .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
    .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .frm_dlc(frm_dlc), .frm_data(frm_data),
    .err_stuff(err_stuff), .err_crc(err_crc), .err_form(err_form)
  );

  typedef struct {
    int          kind;
    logic [28:0] id;
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } exp_t;

  exp_t  sbq[$];
  string tagq[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic strobe_prev = 1'b0;
  logic [28:0] last_id = '0;

  logic raw [0:191];
  int   nraw;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) strobe_prev <= bit_strobe;

  // Monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    exp_t e;
    string t;
    int k;
    if (!rst && (frm_valid || err_stuff || err_crc || err_form)) begin
      k = frm_valid ? 0 : err_stuff ? 1 : err_crc ? 2 : 3;
      check(strobe_prev == 1'b1, "R10", "pulse not in cycle after strobe", 64'(strobe_prev), 64'd1);
      if (sbq.size() == 0) begin
        check(1'b0, "R10", "unexpected result pulse kind", 64'(k), 64'hFF);
      end else begin
        e = sbq.pop_front();
        t = tagq.pop_front();
        check(k == e.kind, t, "result kind", 64'(k), 64'(e.kind));
        if (k == 0 && e.kind == 0) begin
          check(frm_id == e.id, t, "frm_id", 64'(frm_id), 64'(e.id));
          check(frm_ext == e.ext, t, "frm_ext", 64'(frm_ext), 64'(e.ext));
          check(frm_rtr == e.rtr, t, "frm_rtr", 64'(frm_rtr), 64'(e.rtr));
          check(frm_dlc == e.dlc, t, "frm_dlc", 64'(frm_dlc), 64'(e.dlc));
          check(frm_data == e.data, t, "frm_data", frm_data, e.data);
          last_id = e.id;
        end else if (k != 0) begin
          check(frm_id == last_id, "R10", "fields held on error", 64'(frm_id), 64'(last_id));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_strobe = 1'b1;
    @(negedge clk);
    bit_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic b);
    raw[nraw] = b;
    nraw++;
  endtask

  task automatic build(input bit ext, input bit rtr, input logic [28:0] id,
                       input logic [3:0] dlc, input logic [63:0] data, input bit crc_flip);
    logic [14:0] c;
    logic fb;
    int nb;
    int n;
    nraw = 0;
    put(1'b0);
    if (ext) begin
      for (int i = 28; i >= 18; i--) put(id[i]);
      put(1'b1); put(1'b1);
      for (int i = 17; i >= 0; i--) put(id[i]);
      put(rtr); put(1'b0); put(1'b0);
    end else begin
      for (int i = 10; i >= 0; i--) put(id[i]);
      put(rtr); put(1'b0); put(1'b0);
    end
    for (int i = 3; i >= 0; i--) put(dlc[i]);
    nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) put(data[8*k+i]);
    c = '0;
    n = nraw;
    for (int i = 0; i < n; i++) begin
      fb = raw[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    if (crc_flip) c[0] = ~c[0];
    for (int i = 14; i >= 0; i--) put(c[i]);
  endtask

  task automatic xmit(input bit dry, output bit after_crc);
    logic last;
    int run;
    last = 1'b1;
    run = 0;
    for (int i = 0; i < nraw; i++) begin
      if (run == 5) begin
        last = ~last;
        if (!dry) send_bit(last);
        run = 1;
      end
      if (!dry) send_bit(raw[i]);
      if (raw[i] == last) run++;
      else run = 1;
      last = raw[i];
    end
    after_crc = (run == 5);
    if (after_crc && !dry) send_bit(~last);
  endtask

  task automatic frame(input string tag, input int kind, input bit ext, input bit rtr,
                       input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] data,
                       input bit crc_flip, input int bad, input logic ack);
    exp_t e;
    int nb;
    bit a;
    nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    e.kind = kind;
    e.id   = ext ? id : {18'd0, id[10:0]};
    e.ext  = ext;
    e.rtr  = rtr;
    e.dlc  = dlc;
    e.data = (nb == 8) ? data : (data & ((64'd1 << (8*nb)) - 64'd1));
    sbq.push_back(e);
    tagq.push_back(tag);
    build(ext, rtr, id, dlc, data, crc_flip);
    xmit(1'b0, a);
    for (int j = 0; j < 10; j++) send_bit(j == bad ? 1'b0 : (j == 1 ? ack : 1'b1));
    repeat (3) send_bit(1'b1);
  endtask

  initial begin
    exp_t es;
    bit found;
    bit a;
    logic [7:0] pick;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(frm_valid == 0, "R1", "frm_valid in reset", 64'(frm_valid), 0);
    check({err_stuff, err_crc, err_form} == 0, "R1", "error flags in reset",
          64'({err_stuff, err_crc, err_form}), 0);
    check(frm_id == 0 && frm_dlc == 0, "R1", "id/dlc in reset", 64'(frm_id), 0);
    check(frm_data == 0, "R1", "data in reset", frm_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check(frm_valid == 0 && frm_data == 0, "R1", "state after reset release", 64'(frm_valid), 0);
    repeat (4) send_bit(1'b1);

    frame("R2", 0, 0, 0, 29'h123, 4'd2, 64'h3CA5, 0, -1, 1'b1);
    frame("R3", 0, 1, 0, 29'h14D60246, 4'd4, 64'h89ABCDEF, 0, -1, 1'b1);
    frame("R5", 0, 0, 1, 29'h2AA, 4'd5, 64'hFFFF_FFFF, 0, -1, 1'b1);
    frame("R5", 0, 1, 1, 29'h1ABCDE01, 4'd3, 64'h1234, 0, -1, 1'b1);
    frame("R6", 0, 0, 0, 29'h055, 4'd0, 64'hAB, 0, -1, 1'b1);
    frame("R6", 0, 0, 0, 29'h7F0, 4'd15, 64'h0123_4567_89AB_CDEF, 0, -1, 1'b1);
    frame("R6", 0, 1, 0, 29'h00000001, 4'd9, 64'hFEDC_BA98_7654_3210, 0, -1, 1'b1);
    // R4: long runs force stuffing in id and data
    frame("R4", 0, 0, 0, 29'h000, 4'd8, 64'h0, 0, -1, 1'b1);
    frame("R4", 0, 1, 0, 29'h1FFFFFFF, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, -1, 1'b1);
    // R4: search a frame whose CRC ends in a run of five
    found = 0;
    pick = 0;
    for (int d = 0; d < 256 && !found; d++) begin
      build(0, 0, 29'h0F3, 4'd1, 64'(d), 0);
      xmit(1'b1, a);
      if (a) begin found = 1; pick = 8'(d); end
    end
    check(found, "R4", "frame with stuff after CRC exists", 64'(found), 1);
    frame("R4", 0, 0, 0, 29'h0F3, 4'd1, 64'(pick), 0, -1, 1'b1);
    frame("R4", 3, 0, 0, 29'h0F3, 4'd1, 64'(pick), 0, 0, 1'b1);
    // R7: corrupted CRC
    frame("R7", 2, 0, 0, 29'h321, 4'd3, 64'h00C0FFEE, 1, -1, 1'b1);
    frame("R7", 2, 1, 0, 29'h0ABCDEF, 4'd1, 64'h5A, 1, -1, 1'b1);
    // R9: form errors and ACK slot of either value
    frame("R9", 3, 0, 0, 29'h111, 4'd1, 64'h77, 0, 0, 1'b1);
    frame("R9", 3, 0, 0, 29'h222, 4'd1, 64'h77, 0, 2, 1'b1);
    frame("R9", 3, 1, 0, 29'h333, 4'd2, 64'h7788, 0, 6, 1'b1);
    frame("R9", 3, 0, 0, 29'h444, 4'd0, 64'h0, 0, 9, 1'b1);
    frame("R9", 0, 0, 0, 29'h555, 4'd1, 64'h99, 0, -1, 1'b0);
    // R8: six dominant bits from the start bit, then a good frame
    es.kind = 1; es.id = 0; es.ext = 0; es.rtr = 0; es.dlc = 0; es.data = 0;
    sbq.push_back(es);
    tagq.push_back("R8");
    repeat (6) send_bit(1'b0);
    repeat (12) send_bit(1'b1);
    frame("R8", 0, 0, 0, 29'h666, 4'd2, 64'h0102, 0, -1, 1'b1);
    // R11: dominant level without a strobe is not a start bit
    @(negedge clk);
    rx_bit = 1'b0;
    repeat (5) @(negedge clk);
    rx_bit = 1'b1;
    repeat (5) send_bit(1'b1);
    check(sbq.size() == 0, "R11", "no result from unstrobed dominant", 64'(sbq.size()), 0);
    frame("R11", 0, 1, 0, 29'h0F0F0F0F, 4'd1, 64'h3C, 0, -1, 1'b1);
    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "R10", "all expected results produced", 64'(sbq.size()), 0);
    finish_run();
  end
endmodule